// File: doc/BRIEF.md
# Byte-Merging Single-Error-Correcting Word Codec

This block guards 32-bit storage words with a 6-bit single-error-correcting Hamming code, giving a 38-bit stored word. Its read side is purely combinational. It takes a stored word and returns the corrected 32-bit data, a flag for a repaired single-bit fault, a flag for a syndrome that points past the codeword, and the corrected byte chosen by a 2-bit lane address.

Its write side lets a narrower-than-word write update storage that only holds whole words. The caller supplies the stored word as it is now, new lane data and a 4-bit lane mask. The block corrects the old word and replaces only the masked lanes. It then computes new check bits and returns the full 38-bit word to program, one clock after the request. Because the old word is corrected before the merge, the rewrite also removes a single-bit fault in the lanes the write does not touch.

The code is offset by a fixed constant so that the blank storage pattern decodes as clean data: all 38 stored bits set reads back as four bytes of FF.

Top module: `ecc_word_merge`

## Requirements
- R1: Stored word layout: bits [31:0] hold data, bits [37:32] hold check bits c0..c5. In Hamming position numbering 1..38, check bit ck sits at position 2^k and data bit j sits at the j-th position, counted from 1 upward, that is not a power of two. Check bit ck is the XOR of all data bits whose position has bit k set, then XOR-ed with the constant 6'b100111 (c5 is the MSB).
- R2: A stored word with all 38 bits set reads as data 32'hFFFF_FFFF with both flags low, and writing data FFFF_FFFF to all four lanes produces the word 38'h3F_FFFF_FFFF.
- R3: A clean word with any single data bit inverted reads back as the original data, with rd_corrected high and rd_error low.
- R4: A clean word with any single check bit inverted reads back as the unchanged data, with rd_corrected high and rd_error low.
- R5: When the syndrome (stored check XOR recomputed check) is greater than 38, rd_data equals stored bits [31:0] unchanged, rd_error is high and rd_corrected is low. rd_corrected and rd_error are never high together.
- R6: rd_byte equals bits [8*i+7:8*i] of the corrected data, where i is rd_addr (lane 0 is the least significant byte).
- R7: wr_out_vld is low out of reset, is high in the cycle after each clock edge on which wr_valid was high, and is low otherwise.
- R8: In the word produced by a write, lane i holds wr_data lane i when wr_mask[i] is set and the corrected old data lane i when it is clear.
- R9: Every word produced by a write decodes with both flags low, including when the old word had one inverted bit and wr_mask is 0.
- R10: wr_out_word keeps its value on cycles where wr_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_word | input | 38 | Stored word to decode |
| rd_addr | input | 2 | Lane selector for rd_byte |
| rd_data | output | 32 | Corrected data |
| rd_byte | output | 8 | Corrected byte of the selected lane |
| rd_corrected | output | 1 | A single-bit fault was repaired |
| rd_error | output | 1 | Syndrome points past the codeword; data passed unchanged |
| wr_valid | input | 1 | Write-merge request |
| wr_old | input | 38 | Stored word currently held at the target group |
| wr_data | input | 32 | New lane data |
| wr_mask | input | 4 | Lanes to replace |
| wr_out_vld | output | 1 | wr_out_word holds a fresh result |
| wr_out_word | output | 38 | Merged and re-encoded word to program |

## Verification
Every cycle, the assertions check that the two read flags are exclusive and that an out-of-range syndrome leaves the data untouched. They also check that the output-valid flag follows the request by one clock, that masked lanes carry the new bytes, and that every produced word decodes clean. The check-bit values, the correction of each of the 38 single-bit faults, the blank pattern, the lane selection and the cleaning of faults in unmasked lanes can only be shown by the bench. It sweeps data patterns, every fault position, every mask and the syndromes past position 38 against its own Hamming model.

// File: rtl/ecc_merge_pkg.sv
package ecc_merge_pkg;
  parameter int DATA_W  = 32;
  parameter int LANE_W  = 8;
  localparam int N_LANES = DATA_W / LANE_W;
  localparam int SEL_W   = $clog2(N_LANES);

  // smallest r with 2^r >= data + r + 1
  function automatic int chk_bits(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  localparam int CHK_W = chk_bits(DATA_W);
  localparam int CW_W  = DATA_W + CHK_W;

  // Hamming position of data bit j (j-th non-power-of-two position)
  function automatic int unsigned data_pos(input int j);
    int cnt;
    cnt = 0;
    for (int unsigned p = 1; p < (1 << CHK_W); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == j) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  function automatic logic [CHK_W-1:0] raw_parity(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] par;
    int unsigned p;
    par = '0;
    for (int j = 0; j < DATA_W; j++) begin
      p = data_pos(j);
      for (int k = 0; k < CHK_W; k++)
        if (p[k]) par[k] = par[k] ^ d[j];
    end
    return par;
  endfunction

  // offset that makes the all-ones word a valid codeword
  localparam logic [CHK_W-1:0] CHK_INV = ~raw_parity({DATA_W{1'b1}});
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_merge_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  assign chk = raw_parity(data) ^ CHK_INV;
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_merge_pkg::*;
(
  input  logic [CW_W-1:0]   word,
  output logic [DATA_W-1:0] data_fix,
  output logic [CHK_W-1:0]  syndrome,
  output logic              corrected,
  output logic              uncorr
);
  logic [CHK_W-1:0] chk_calc;

  ecc_encoder enc_i (
    .data (word[DATA_W-1:0]),
    .chk  (chk_calc)
  );

  assign syndrome = word[CW_W-1:DATA_W] ^ chk_calc;
  assign uncorr   = (syndrome > CHK_W'(CW_W));
  assign corrected = (syndrome != '0) && !uncorr;

  for (genvar j = 0; j < DATA_W; j++) begin : g_fix
    localparam int unsigned POS = data_pos(j);
    assign data_fix[j] = word[j] ^ (syndrome == CHK_W'(POS));
  end
endmodule

// File: rtl/lane_merge.sv
module lane_merge
  import ecc_merge_pkg::*;
(
  input  logic [DATA_W-1:0]  old_data,
  input  logic [DATA_W-1:0]  new_data,
  input  logic [N_LANES-1:0] mask,
  output logic [DATA_W-1:0]  merged
);
  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    assign merged[i*LANE_W +: LANE_W] = mask[i] ? new_data[i*LANE_W +: LANE_W]
                                                : old_data[i*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ecc_word_merge.sv
module ecc_word_merge
  import ecc_merge_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW_W-1:0]    rd_word,
  input  logic [SEL_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic [LANE_W-1:0]  rd_byte,
  output logic               rd_corrected,
  output logic               rd_error,
  input  logic               wr_valid,
  input  logic [CW_W-1:0]    wr_old,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [N_LANES-1:0] wr_mask,
  output logic               wr_out_vld,
  output logic [CW_W-1:0]    wr_out_word
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // read path, combinational
  logic [CHK_W-1:0]  rd_syn;
  logic [LANE_W-1:0] rd_lanes [N_LANES];

  ecc_decoder rd_dec_i (
    .word      (rd_word),
    .data_fix  (rd_data),
    .syndrome  (rd_syn),
    .corrected (rd_corrected),
    .uncorr    (rd_error)
  );

  for (genvar i = 0; i < N_LANES; i++) begin : g_rd_lane
    assign rd_lanes[i] = rd_data[i*LANE_W +: LANE_W];
  end
  assign rd_byte = rd_lanes[rd_addr];

  // write path: correct old, merge, re-encode
  logic [DATA_W-1:0] old_fix;
  logic [CHK_W-1:0]  old_syn;
  logic              old_corr, old_uncorr;
  logic [DATA_W-1:0] merged;
  logic [CHK_W-1:0]  merged_chk;

  ecc_decoder wr_dec_i (
    .word      (wr_old),
    .data_fix  (old_fix),
    .syndrome  (old_syn),
    .corrected (old_corr),
    .uncorr    (old_uncorr)
  );

  lane_merge merge_i (
    .old_data (old_fix),
    .new_data (wr_data),
    .mask     (wr_mask),
    .merged   (merged)
  );

  ecc_encoder wr_enc_i (
    .data (merged),
    .chk  (merged_chk)
  );

  // next state
  logic            vld_d, vld_q;
  logic [CW_W-1:0] word_d, word_q;

  always_comb begin
    vld_d  = wr_valid;
    word_d = {merged_chk, merged};
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= 1'b0;
    else             vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_valid) word_q <= word_d;
  end

  assign wr_out_vld  = vld_q;
  assign wr_out_word = word_q;
endmodule

// File: rtl/ecc_word_merge_chk.sv
module ecc_word_merge_chk
  import ecc_merge_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [CW_W-1:0]    rd_word,
  input logic [DATA_W-1:0]  rd_data,
  input logic               rd_corrected,
  input logic               rd_error,
  input logic               wr_valid,
  input logic [DATA_W-1:0]  wr_data,
  input logic [N_LANES-1:0] wr_mask,
  input logic               wr_out_vld,
  input logic [CW_W-1:0]    wr_out_word
);
  logic [DATA_W-1:0] out_fix;
  logic [CHK_W-1:0]  out_syn;
  logic              out_corr, out_uncorr;

  ecc_decoder out_dec_i (
    .word      (wr_out_word),
    .data_fix  (out_fix),
    .syndrome  (out_syn),
    .corrected (out_corr),
    .uncorr    (out_uncorr)
  );

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_corrected, rd_error})); // R5

  AST_ERROR_PASSES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_error |-> (rd_data == rd_word[DATA_W-1:0])); // R5

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> wr_out_vld); // R7

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !wr_out_vld); // R7

  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_out_vld && !wr_valid) |=> $stable(wr_out_word)); // R10

  AST_OUT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_vld |-> (out_syn == '0)); // R9

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane_chk
    AST_MASKED_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_mask[i]) |=>
        (wr_out_word[i*LANE_W +: LANE_W] == $past(wr_data[i*LANE_W +: LANE_W]))); // R8
  end
endmodule

bind ecc_word_merge ecc_word_merge_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .rd_word      (rd_word),
  .rd_data      (rd_data),
  .rd_corrected (rd_corrected),
  .rd_error     (rd_error),
  .wr_valid     (wr_valid),
  .wr_data      (wr_data),
  .wr_mask      (wr_mask),
  .wr_out_vld   (wr_out_vld),
  .wr_out_word  (wr_out_word)
);

// File: tb/ecc_word_merge_tb_top.sv
module ecc_word_merge_tb_top;
  logic        clk;
  logic        rst_n;
  logic [37:0] rd_word;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic [7:0]  rd_byte;
  logic        rd_corrected, rd_error;
  logic        wr_valid;
  logic [37:0] wr_old;
  logic [31:0] wr_data;
  logic [3:0]  wr_mask;
  logic        wr_out_vld;
  logic [37:0] wr_out_word;

  int tests = 0;
  int fails = 0;

  ecc_word_merge dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_word(rd_word), .rd_addr(rd_addr), .rd_data(rd_data), .rd_byte(rd_byte),
    .rd_corrected(rd_corrected), .rd_error(rd_error),
    .wr_valid(wr_valid), .wr_old(wr_old), .wr_data(wr_data), .wr_mask(wr_mask),
    .wr_out_vld(wr_out_vld), .wr_out_word(wr_out_word)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // bench model of the R1 layout
  function automatic int tb_pos(input int j);
    int cnt;
    cnt = 0;
    for (int p = 1; p < 64; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == j) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  function automatic logic [37:0] tb_encode(input logic [31:0] d);
    logic [5:0] c;
    c = 6'b0;
    for (int j = 0; j < 32; j++)
      for (int k = 0; k < 6; k++)
        if (((tb_pos(j) >> k) & 1) != 0) c[k] = c[k] ^ d[j];
    c = c ^ 6'b100111;
    return {c, d};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [37:0] w,
                          input logic [31:0] ed, input logic ec, input logic ee);
    rd_word = w;
    #1;
    check(req, {rd_data, 30'b0, rd_corrected, rd_error}, {ed, 30'b0, ec, ee});
  endtask

  task automatic do_write(input logic [37:0] old, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    wr_valid = 1'b1; wr_old = old; wr_data = d; wr_mask = m;
    @(posedge clk);
    #1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  function automatic logic [31:0] tb_merge(input logic [31:0] o, input logic [31:0] n,
                                           input logic [3:0] m);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = m[i] ? n[i*8 +: 8] : o[i*8 +: 8];
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] pats [6];
    logic [37:0] w, out_hold;
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'hA5C3_0F71;
    pats[3] = 32'h1234_5678; pats[4] = 32'h8000_0001; pats[5] = 32'h5A5A_F00D;
    rst_n = 1'b0; wr_valid = 1'b0; wr_old = '0; wr_data = '0; wr_mask = '0;
    rd_word = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset valid", {63'b0, wr_out_vld}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R7 after reset idle", {63'b0, wr_out_vld}, 64'd0);

    // R2 blank pattern
    read_chk("R2 blank read", {38{1'b1}}, 32'hFFFF_FFFF, 1'b0, 1'b0);
    check("R1 encode blank", {26'b0, tb_encode(32'hFFFF_FFFF)}, {26'b0, {38{1'b1}}});

    // R1/R3/R4 every single-bit fault on several patterns
    foreach (pats[p]) begin
      w = tb_encode(pats[p]);
      read_chk("R1 clean word", w, pats[p], 1'b0, 1'b0);
      for (int b = 0; b < 38; b++) begin
        if (b < 32) read_chk("R3 data bit flip", w ^ (38'd1 << b), pats[p], 1'b1, 1'b0);
        else        read_chk("R4 check bit flip", w ^ (38'd1 << b), pats[p], 1'b1, 1'b0);
      end
      // R5 syndromes past 38: check5 plus data bit j with position xor 32 > 38
      for (int j = 0; j < 32; j++) begin
        if ((32 ^ tb_pos(j)) > 38)
          read_chk("R5 out of range", w ^ (38'd1 << 37) ^ (38'd1 << j),
                   pats[p] ^ (32'd1 << j), 1'b0, 1'b1);
      end
      // R6 lane select under a corrected fault
      for (int a = 0; a < 4; a++) begin
        rd_addr = 2'(a);
        rd_word = w ^ (38'd1 << 5);
        #1;
        check("R6 lane byte", {56'b0, rd_byte}, {56'b0, pats[p][a*8 +: 8]});
      end
    end

    // R8/R9 write merges over every mask and fault position
    for (int pp = 0; pp < 2; pp++) begin
      logic [31:0] od, nd, ed;
      od = pats[2 + pp]; nd = pats[5 - pp];
      for (int m = 0; m < 16; m++) begin
        for (int b = -1; b < 38; b++) begin
          w = tb_encode(od);
          if (b >= 0) w = w ^ (38'd1 << b);
          do_write(w, nd, 4'(m));
          ed = tb_merge(od, nd, 4'(m));
          check("R8 merged word", {26'b0, wr_out_word}, {26'b0, tb_encode(ed)});
          if (b == 3 && m == 0) begin
            read_chk("R9 scrub clean", wr_out_word, od, 1'b0, 1'b0);
          end
        end
      end
    end

    // R2 blank write
    do_write('0, 32'hFFFF_FFFF, 4'hF);
    check("R2 blank write", {26'b0, wr_out_word}, {26'b0, {38{1'b1}}});
    read_chk("R9 write decodes clean", wr_out_word, 32'hFFFF_FFFF, 1'b0, 1'b0);

    // R7/R10 valid pulse then hold
    @(negedge clk);
    wr_valid = 1'b1; wr_old = tb_encode(32'h0); wr_data = 32'h0BAD_CAFE; wr_mask = 4'h3;
    @(posedge clk); #1;
    check("R7 valid one cycle after", {63'b0, wr_out_vld}, 64'd1);
    out_hold = wr_out_word;
    check("R8 low lanes", {26'b0, out_hold}, {26'b0, tb_encode(32'h0000_CAFE)});
    @(negedge clk);
    wr_valid = 1'b0; wr_data = 32'hDEAD_BEEF; wr_mask = 4'hF; wr_old = '1;
    repeat (3) @(posedge clk);
    #1;
    check("R7 valid drops", {63'b0, wr_out_vld}, 64'd0);
    check("R10 word holds", {26'b0, wr_out_word}, {26'b0, out_hold});

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule